// File: doc/BRIEF.md
# I2C Target Controller with Event Status Codes

This block is the responding side of a two-wire serial bus with 7-bit addressing. It watches the clock and data lines after a two-stage synchroniser. It answers when it sees its own programmable address, and, if enabled, the all-zero broadcast address. Each bus event it takes part in is summarised as an 8-bit status code, and an interrupt flag is raised with it. Software reads the code, acts on it and clears the flag. While the flag is pending after an event where the transfer goes on, the block holds the clock line low, so the bus master waits for software.

Software decides acknowledge or not-acknowledge through an acknowledge-enable input. It reads received bytes from a data output and supplies bytes to send on a transmit-data input. These bytes are captured when the flag is cleared. A separate strobe input tells the block that the local master has just lost arbitration. The next address match then reports a distinct code. Both bus lines are driven as open-drain pull-down enables.

Top module: `i2c_slave_status`

## Requirements
- R1: During and right after reset, status reads F8h, the interrupt flag is low, and neither bus line is pulled low.
- R2: Own address with write bit (address byte = own_addr<<1) while ack_en is high is acknowledged and gives status 60h. If arb_lost pulsed since the last address match, it gives 68h.
- R3: Address byte 00h is acknowledged only while gc_en is high, giving 70h, or 78h after an arb_lost pulse. With gc_en low it is not acknowledged and raises no flag.
- R4: A byte written after the own address is placed on rx_data. SDA is pulled low in the ninth clock when ack_en is high at the end of the eighth bit, giving 80h, and left high otherwise, giving 88h.
- R5: A byte written after the broadcast address gives 90h when acknowledged and 98h when not.
- R6: After the block has withheld an acknowledge, it acknowledges no further byte and reports no data event until the next START.
- R7: A STOP or a repeated START while the block is addressed gives status A0h. Neither raises a flag when it is not addressed.
- R8: Own address with read bit (own_addr<<1 | 1) gives A8h, or B0h after an arb_lost pulse. The byte on tx_data when the flag is cleared is then shifted out MSB first.
- R9: After a sent byte, a master ACK gives B8h and a master NACK gives C0h, after which SDA stays released. A byte loaded while ack_en is low is the last one. If the master ACKs it, the status is C8h and SDA stays released, so further reads return FFh.
- R10: A flag_clr pulse drops the flag and makes status read F8h. After events where the transfer continues (60h, 68h, 70h, 78h, 80h, 90h, A8h, B0h, B8h), SCL is held low until the flag is cleared.
- R11: An address byte that matches neither address, or any address while ack_en is low, is not acknowledged and raises no flag.
- R12: When the block releases SCL after a stretch, SDA does not change in that same cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| scl_i | input | 1 | Serial clock line as seen on the bus |
| sda_i | input | 1 | Serial data line as seen on the bus |
| scl_oe | output | 1 | Pull the clock line low (stretch) |
| sda_oe | output | 1 | Pull the data line low |
| own_addr | input | 7 | Own bus address |
| gc_en | input | 1 | Answer the all-zero broadcast address |
| ack_en | input | 1 | Acknowledge received bytes; low when loading the last byte to send |
| arb_lost | input | 1 | Strobe: the local master lost arbitration |
| tx_data | input | 8 | Byte to send, captured on flag clear |
| flag_clr | input | 1 | Clear the interrupt flag |
| irq_flag | output | 1 | Event pending |
| status | output | 8 | Event code, F8h when none is pending |
| rx_data | output | 8 | Last received byte |

## Verification
The hardest states to reach are the codes that depend on earlier history. These are the arbitration-loss variants and the withheld-acknowledge state that persists until the next START. Both require software to change its inputs while the bus master is frozen by clock stretching. The bench's software model reacts to each flag from a scoreboard entry. That entry says which byte to load and what acknowledge setting to leave behind, so a NACK can be set up in the middle of a transfer. The arbitration strobe is pulsed just before a START or a repeated START.

// File: rtl/i2c_ss_pkg.sv
package i2c_ss_pkg;
  localparam int BYTE_W = 8;
  localparam int ADDR_W = 7;

  typedef enum logic [1:0] {PH_IDLE, PH_ADDR, PH_RX, PH_TX} phase_t;

  localparam logic [7:0] ST_NONE      = 8'hF8;
  localparam logic [7:0] ST_WR_OWN    = 8'h60;
  localparam logic [7:0] ST_WR_OWN_AL = 8'h68;
  localparam logic [7:0] ST_BC        = 8'h70;
  localparam logic [7:0] ST_BC_AL     = 8'h78;
  localparam logic [7:0] ST_RX_ACK    = 8'h80;
  localparam logic [7:0] ST_RX_NAK    = 8'h88;
  localparam logic [7:0] ST_BCRX_ACK  = 8'h90;
  localparam logic [7:0] ST_BCRX_NAK  = 8'h98;
  localparam logic [7:0] ST_END       = 8'hA0;
  localparam logic [7:0] ST_RD_OWN    = 8'hA8;
  localparam logic [7:0] ST_RD_OWN_AL = 8'hB0;
  localparam logic [7:0] ST_TX_ACK    = 8'hB8;
  localparam logic [7:0] ST_TX_NAK    = 8'hC0;
  localparam logic [7:0] ST_TX_LAST   = 8'hC8;

  function automatic logic [7:0] addr_code(input logic rd, input logic bc, input logic al);
    if (rd)      return al ? ST_RD_OWN_AL : ST_RD_OWN;
    else if (bc) return al ? ST_BC_AL : ST_BC;
    else         return al ? ST_WR_OWN_AL : ST_WR_OWN;
  endfunction

  function automatic logic [7:0] rx_code(input logic bc, input logic ack);
    if (bc) return ack ? ST_BCRX_ACK : ST_BCRX_NAK;
    else    return ack ? ST_RX_ACK : ST_RX_NAK;
  endfunction
endpackage

// File: rtl/i2c_ss_sync.sv
module i2c_ss_sync #(
  parameter int STAGES = 2,
  parameter int LINES  = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [LINES-1:0] d,
  output logic [LINES-1:0] q
);
  for (genvar g = 0; g < LINES; g++) begin : g_line
    logic [STAGES-1:0] chain;
    always_ff @(posedge clk) begin
      if (rst) chain <= '1;
      else     chain <= {chain[STAGES-2:0], d[g]};
    end
    assign q[g] = chain[STAGES-1];
  end
endmodule

// File: rtl/i2c_ss_cond.sv
module i2c_ss_cond (
  input  logic clk,
  input  logic rst,
  input  logic scl_s,
  input  logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_det,
  output logic stop_det
);
  logic scl_q, sda_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      scl_q <= 1'b1;
      sda_q <= 1'b1;
    end else begin
      scl_q <= scl_s;
      sda_q <= sda_s;
    end
  end

  assign scl_rise  = scl_s & ~scl_q;
  assign scl_fall  = ~scl_s & scl_q;
  assign start_det = scl_s & scl_q & sda_q & ~sda_s;
  assign stop_det  = scl_s & scl_q & ~sda_q & sda_s;
endmodule

// File: rtl/i2c_ss_core.sv
module i2c_ss_core
  import i2c_ss_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              scl_rise,
  input  logic              scl_fall,
  input  logic              start_det,
  input  logic              stop_det,
  input  logic              sda_s,
  input  logic [ADDR_W-1:0] own_addr,
  input  logic              gc_en,
  input  logic              ack_en,
  input  logic              arb_lost,
  input  logic [BYTE_W-1:0] tx_data,
  input  logic              flag_clr,
  output logic              scl_oe,
  output logic              sda_oe,
  output logic              irq_flag,
  output logic [7:0]        status,
  output logic [BYTE_W-1:0] rx_data
);
  localparam int CNT_W = $clog2(BYTE_W + 2);
  localparam logic [CNT_W-1:0] ACK_SLOT = CNT_W'(BYTE_W);
  localparam logic [CNT_W-1:0] END_SLOT = CNT_W'(BYTE_W + 1);

  phase_t            phase;
  logic [CNT_W-1:0]  cnt;
  logic [BYTE_W-1:0] shreg, txsh;
  logic              stretch, addressed, arb_pend;
  logic              bc_mode, rd_mode, acked, last, mack;
  logic              own_hit, bc_hit;

  assign own_hit = (shreg[BYTE_W-1:1] == own_addr);
  assign bc_hit  = gc_en && (shreg == '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      phase     <= PH_IDLE;
      cnt       <= '0;
      shreg     <= '0;
      txsh      <= '0;
      stretch   <= 1'b0;
      scl_oe    <= 1'b0;
      sda_oe    <= 1'b0;
      irq_flag  <= 1'b0;
      status    <= ST_NONE;
      rx_data   <= '0;
      addressed <= 1'b0;
      arb_pend  <= 1'b0;
      bc_mode   <= 1'b0;
      rd_mode   <= 1'b0;
      acked     <= 1'b0;
      last      <= 1'b0;
      mack      <= 1'b0;
    end else begin
      // clock release lags the stretch state by one cycle so SDA settles first
      scl_oe <= stretch;
      if (arb_lost) arb_pend <= 1'b1;

      if (flag_clr && irq_flag) begin
        irq_flag <= 1'b0;
        status   <= ST_NONE;
        stretch  <= 1'b0;
        if (phase == PH_TX && stretch) begin
          txsh   <= tx_data;
          sda_oe <= ~tx_data[BYTE_W-1];
          last   <= ~ack_en;
        end
      end

      if (stop_det || start_det) begin
        phase   <= stop_det ? PH_IDLE : PH_ADDR;
        cnt     <= '0;
        sda_oe  <= 1'b0;
        stretch <= 1'b0;
        if (addressed) begin
          status    <= ST_END;
          irq_flag  <= 1'b1;
          addressed <= 1'b0;
        end
      end else if (scl_rise && phase != PH_IDLE) begin
        cnt <= cnt + 1'b1;
        if ((phase == PH_ADDR || phase == PH_RX) && cnt < ACK_SLOT)
          shreg <= {shreg[BYTE_W-2:0], sda_s};
        if (phase == PH_TX && cnt == ACK_SLOT)
          mack <= ~sda_s;
      end else if (scl_fall && phase != PH_IDLE) begin
        if (cnt == ACK_SLOT) begin
          // start of the acknowledge slot
          case (phase)
            PH_ADDR: begin
              if (ack_en && (own_hit || bc_hit)) begin
                sda_oe  <= 1'b1;
                rd_mode <= own_hit & shreg[0];
                bc_mode <= ~own_hit;
              end else begin
                phase <= PH_IDLE;
              end
            end
            PH_RX: begin
              rx_data <= shreg;
              acked   <= ack_en;
              sda_oe  <= ack_en;
            end
            PH_TX:   sda_oe <= 1'b0;
            default: sda_oe <= 1'b0;
          endcase
        end else if (cnt == END_SLOT) begin
          // end of the acknowledge slot: report the event
          cnt      <= '0;
          sda_oe   <= 1'b0;
          irq_flag <= 1'b1;
          case (phase)
            PH_ADDR: begin
              status    <= addr_code(rd_mode, bc_mode, arb_pend);
              arb_pend  <= 1'b0;
              addressed <= 1'b1;
              stretch   <= 1'b1;
              phase     <= rd_mode ? PH_TX : PH_RX;
            end
            PH_RX: begin
              status <= rx_code(bc_mode, acked);
              if (acked) stretch <= 1'b1;
              else       phase   <= PH_IDLE;
            end
            PH_TX: begin
              if (mack && !last) begin
                status  <= ST_TX_ACK;
                stretch <= 1'b1;
              end else begin
                status <= mack ? ST_TX_LAST : ST_TX_NAK;
                phase  <= PH_IDLE;
              end
            end
            default: irq_flag <= irq_flag;
          endcase
        end else if (phase == PH_TX && cnt != '0) begin
          txsh   <= txsh << 1;
          sda_oe <= ~txsh[BYTE_W-2];
        end
      end
    end
  end
endmodule

// File: rtl/i2c_slave_status.sv
module i2c_slave_status
  import i2c_ss_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              scl_i,
  input  logic              sda_i,
  output logic              scl_oe,
  output logic              sda_oe,
  input  logic [ADDR_W-1:0] own_addr,
  input  logic              gc_en,
  input  logic              ack_en,
  input  logic              arb_lost,
  input  logic [BYTE_W-1:0] tx_data,
  input  logic              flag_clr,
  output logic              irq_flag,
  output logic [7:0]        status,
  output logic [BYTE_W-1:0] rx_data
);
  logic [1:0] line_s;
  logic scl_rise, scl_fall, start_det, stop_det;

  i2c_ss_sync #(.STAGES(SYNC_STAGES), .LINES(2)) u_sync (
    .clk (clk),
    .rst (rst),
    .d   ({scl_i, sda_i}),
    .q   (line_s)
  );

  i2c_ss_cond u_cond (
    .clk       (clk),
    .rst       (rst),
    .scl_s     (line_s[1]),
    .sda_s     (line_s[0]),
    .scl_rise  (scl_rise),
    .scl_fall  (scl_fall),
    .start_det (start_det),
    .stop_det  (stop_det)
  );

  i2c_ss_core u_core (
    .clk       (clk),
    .rst       (rst),
    .scl_rise  (scl_rise),
    .scl_fall  (scl_fall),
    .start_det (start_det),
    .stop_det  (stop_det),
    .sda_s     (line_s[0]),
    .own_addr  (own_addr),
    .gc_en     (gc_en),
    .ack_en    (ack_en),
    .arb_lost  (arb_lost),
    .tx_data   (tx_data),
    .flag_clr  (flag_clr),
    .scl_oe    (scl_oe),
    .sda_oe    (sda_oe),
    .irq_flag  (irq_flag),
    .status    (status),
    .rx_data   (rx_data)
  );
endmodule

// File: rtl/i2c_slave_status_chk.sv
module i2c_slave_status_chk (
  input logic       clk,
  input logic       rst,
  input logic       irq_flag,
  input logic [7:0] status,
  input logic       scl_oe,
  input logic       sda_oe
);
  p_reset_idle_r1: assert property (@(posedge clk)
    rst |=> (status == 8'hF8 && !irq_flag && !scl_oe && !sda_oe));

  p_no_event_code_r10: assert property (@(posedge clk) disable iff (rst)
    !irq_flag |-> status == 8'hF8);

  // R2: every pending code is one of the defined event codes
  p_event_code_r2: assert property (@(posedge clk) disable iff (rst)
    irq_flag |-> status inside {8'h60, 8'h68, 8'h70, 8'h78, 8'h80, 8'h88, 8'h90,
                                8'h98, 8'hA0, 8'hA8, 8'hB0, 8'hB8, 8'hC0, 8'hC8});

  p_stretch_pending_r10: assert property (@(posedge clk) disable iff (rst)
    scl_oe |-> (irq_flag || $past(irq_flag)));

  p_sda_settled_r12: assert property (@(posedge clk) disable iff (rst)
    $fell(scl_oe) |-> $stable(sda_oe));
endmodule

bind i2c_slave_status i2c_slave_status_chk u_chk (
  .clk      (clk),
  .rst      (rst),
  .irq_flag (irq_flag),
  .status   (status),
  .scl_oe   (scl_oe),
  .sda_oe   (sda_oe)
);

// File: tb/i2c_slave_status_tb.sv
module i2c_slave_status_tb;
  localparam int CLK_PERIOD = 10;
  localparam int Q  = 6;
  localparam int H  = 12;
  localparam int WD = 100000;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic m_scl_rel = 1'b1, m_sda_rel = 1'b1;
  logic scl_oe, sda_oe, irq_flag;
  logic [6:0] own_addr = 7'h2A;
  logic gc_en = 1'b0, ack_en = 1'b1, arb_lost = 1'b0, flag_clr = 1'b0;
  logic [7:0] tx_data = 8'h00;
  logic [7:0] status, rx_data;
  logic scl_i, sda_i;

  assign scl_i = m_scl_rel & ~scl_oe;
  assign sda_i = m_sda_rel & ~sda_oe;

  always #(CLK_PERIOD/2) clk = ~clk;

  i2c_slave_status u_dut (
    .clk(clk), .rst(rst), .scl_i(scl_i), .sda_i(sda_i),
    .scl_oe(scl_oe), .sda_oe(sda_oe), .own_addr(own_addr), .gc_en(gc_en),
    .ack_en(ack_en), .arb_lost(arb_lost), .tx_data(tx_data), .flag_clr(flag_clr),
    .irq_flag(irq_flag), .status(status), .rx_data(rx_data)
  );

  typedef struct packed {
    logic [7:0] code;
    logic [7:0] rx;
    logic       chk_rx;
    logic       hold;
    logic       load;
    logic [7:0] tx;
    logic       last;
    logic       ackn;
  } ev_t;

  ev_t sbq[$];
  int n_chk = 0;
  int n_fail = 0;

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  task automatic expect_ev(input logic [7:0] code, input logic [7:0] rx, input bit chk_rx,
                           input bit hold, input bit load, input logic [7:0] tx,
                           input bit last, input bit ackn);
    ev_t e;
    e.code = code; e.rx = rx; e.chk_rx = chk_rx; e.hold = hold;
    e.load = load; e.tx = tx; e.last = last; e.ackn = ackn;
    sbq.push_back(e);
  endtask

  // software model and scoreboard monitor
  initial begin
    ev_t e;
    forever begin
      @(negedge clk);
      if (!rst && irq_flag) begin
        if (sbq.size() == 0) begin
          check(1'b0, "R7/R11 unexpected event", status, 8'hF8);
          e = '0;
          e.ackn = ack_en;
        end else begin
          e = sbq.pop_front();
          check(status == e.code, "R2-R9 status code", status, e.code);
          if (e.chk_rx) check(rx_data == e.rx, "R4 rx_data", rx_data, e.rx);
        end
        if (e.hold) begin
          repeat (3*H) @(negedge clk);
          check(scl_i == 1'b0, "R10 clock held while pending", scl_i, 0);
        end
        if (e.load) begin
          tx_data = e.tx;
          ack_en  = !e.last;
        end
        flag_clr = 1'b1;
        @(negedge clk);
        flag_clr = 1'b0;
        ack_en   = e.ackn;
        check(status == 8'hF8 && !irq_flag, "R10 cleared status", {irq_flag, status}, 8'hF8);
      end
    end
  end

  // bus master model
  task automatic wait_scl_high();
    while (!scl_i) @(negedge clk);
  endtask

  task automatic wbit(input logic b);
    repeat (Q) @(negedge clk);
    m_sda_rel = b;
    repeat (Q) @(negedge clk);
    m_scl_rel = 1'b1;
    wait_scl_high();
    repeat (H) @(negedge clk);
    m_scl_rel = 1'b0;
  endtask

  task automatic rbit(output logic v);
    repeat (Q) @(negedge clk);
    m_sda_rel = 1'b1;
    repeat (Q) @(negedge clk);
    m_scl_rel = 1'b1;
    wait_scl_high();
    repeat (H/2) @(negedge clk);
    v = sda_i;
    repeat (H/2) @(negedge clk);
    m_scl_rel = 1'b0;
  endtask

  task automatic wbyte(input logic [7:0] b, output bit ack);
    logic v;
    for (int i = 7; i >= 0; i--) wbit(b[i]);
    rbit(v);
    ack = !v;
  endtask

  task automatic rbyte(output logic [7:0] b);
    logic v;
    for (int i = 7; i >= 0; i--) begin
      rbit(v);
      b[i] = v;
    end
  endtask

  task automatic m_start();
    repeat (Q) @(negedge clk);
    m_sda_rel = 1'b1;
    repeat (Q) @(negedge clk);
    m_scl_rel = 1'b1;
    wait_scl_high();
    repeat (H) @(negedge clk);
    m_sda_rel = 1'b0;
    repeat (H) @(negedge clk);
    m_scl_rel = 1'b0;
  endtask

  task automatic m_stop();
    repeat (Q) @(negedge clk);
    m_sda_rel = 1'b0;
    repeat (Q) @(negedge clk);
    m_scl_rel = 1'b1;
    wait_scl_high();
    repeat (H) @(negedge clk);
    m_sda_rel = 1'b1;
    repeat (2*H) @(negedge clk);
  endtask

  task automatic pulse_arb();
    @(negedge clk);
    arb_lost = 1'b1;
    @(negedge clk);
    arb_lost = 1'b0;
  endtask

  initial begin
    repeat (WD) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual running expected done");
    finish_run();
  end

  initial begin
    bit ack;
    logic [7:0] rb;
    repeat (4) @(negedge clk);
    check(status == 8'hF8 && !irq_flag && !scl_oe && !sda_oe, "R1 in reset",
          {irq_flag, scl_oe, sda_oe, status}, 8'hF8);
    rst = 1'b0;
    @(negedge clk);
    check(status == 8'hF8 && !irq_flag && !scl_oe && !sda_oe, "R1 after reset",
          {irq_flag, scl_oe, sda_oe, status}, 8'hF8);
    repeat (10) @(negedge clk);

    // R2 R4 R6 R7: own write, acked and withheld data, stop
    expect_ev(8'h60, 0, 0, 1, 0, 0, 0, 1);
    m_start();
    wbyte(8'h54, ack); check(ack, "R2 own write address ack", ack, 1);
    expect_ev(8'h80, 8'hA5, 1, 0, 0, 0, 0, 1);
    wbyte(8'hA5, ack); check(ack, "R4 data ack", ack, 1);
    expect_ev(8'h80, 8'h3C, 1, 0, 0, 0, 0, 0);
    wbyte(8'h3C, ack); check(ack, "R4 data ack 2", ack, 1);
    expect_ev(8'h88, 8'h77, 1, 0, 0, 0, 0, 1);
    wbyte(8'h77, ack); check(!ack, "R4 data nack", ack, 0);
    wbyte(8'h12, ack); check(!ack, "R6 no ack after withheld ack", ack, 0);
    expect_ev(8'hA0, 0, 0, 0, 0, 0, 0, 1);
    m_stop();

    // R11: mismatch and ack disabled
    m_start();
    wbyte(8'h40, ack); check(!ack, "R11 foreign address", ack, 0);
    m_stop();
    ack_en = 1'b0;
    m_start();
    wbyte(8'h54, ack); check(!ack, "R11 ack_en low", ack, 0);
    m_stop();
    ack_en = 1'b1;

    // R3: broadcast disabled then enabled; R5, R6, R7 repeated start, R2 arbitration variant
    m_start();
    wbyte(8'h00, ack); check(!ack, "R3 broadcast disabled", ack, 0);
    m_stop();
    gc_en = 1'b1;
    expect_ev(8'h70, 0, 0, 0, 0, 0, 0, 1);
    m_start();
    wbyte(8'h00, ack); check(ack, "R3 broadcast ack", ack, 1);
    expect_ev(8'h90, 8'h11, 1, 0, 0, 0, 0, 0);
    wbyte(8'h11, ack); check(ack, "R5 broadcast data ack", ack, 1);
    expect_ev(8'h98, 8'h22, 1, 0, 0, 0, 0, 1);
    wbyte(8'h22, ack); check(!ack, "R5 broadcast data nack", ack, 0);
    wbyte(8'h33, ack); check(!ack, "R6 still withheld", ack, 0);
    pulse_arb();
    expect_ev(8'hA0, 0, 0, 0, 0, 0, 0, 1);
    expect_ev(8'h68, 0, 0, 0, 0, 0, 0, 1);
    m_start();
    wbyte(8'h54, ack); check(ack, "R2 own address after arbitration loss", ack, 1);
    expect_ev(8'hA0, 0, 0, 0, 0, 0, 0, 1);
    m_stop();
    pulse_arb();
    expect_ev(8'h78, 0, 0, 0, 0, 0, 0, 1);
    m_start();
    wbyte(8'h00, ack); check(ack, "R3 broadcast after arbitration loss", ack, 1);
    expect_ev(8'hA0, 0, 0, 0, 0, 0, 0, 1);
    m_stop();

    // R8 R9: own read, master ack then nack
    expect_ev(8'hA8, 0, 0, 0, 1, 8'hC3, 0, 1);
    m_start();
    wbyte(8'h55, ack); check(ack, "R8 own read address ack", ack, 1);
    rbyte(rb); check(rb == 8'hC3, "R8 first byte", rb, 8'hC3);
    expect_ev(8'hB8, 0, 0, 0, 1, 8'h5A, 0, 1);
    wbit(1'b0);
    rbyte(rb); check(rb == 8'h5A, "R9 second byte", rb, 8'h5A);
    expect_ev(8'hC0, 0, 0, 0, 0, 0, 0, 1);
    wbit(1'b1);
    repeat (H) @(negedge clk);
    check(sda_oe == 1'b0, "R9 SDA released after master nack", sda_oe, 0);
    expect_ev(8'hA0, 0, 0, 0, 0, 0, 0, 1);
    m_stop();

    // R8 R9: read after arbitration loss, last byte acked
    pulse_arb();
    expect_ev(8'hB0, 0, 0, 0, 1, 8'h81, 1, 1);
    m_start();
    wbyte(8'h55, ack); check(ack, "R8 read after arbitration loss", ack, 1);
    rbyte(rb); check(rb == 8'h81, "R8 last byte", rb, 8'h81);
    expect_ev(8'hC8, 0, 0, 0, 0, 0, 0, 1);
    wbit(1'b0);
    rbyte(rb); check(rb == 8'hFF, "R9 released after last byte", rb, 8'hFF);
    wbit(1'b1);
    expect_ev(8'hA0, 0, 0, 0, 0, 0, 0, 1);
    m_stop();

    repeat (4*H) @(negedge clk);
    check(sbq.size() == 0, "R7 all expected events seen", sbq.size(), 0);
    finish_run();
  end
endmodule